// File: doc/BRIEF.md
# Timestamp-Histogram Event Tagger

This block builds events from a stream of hits that carry only a timestamp, a detector type and a hit index, with no event number. Every hit is counted into a ring of coarse time bins, eight ticks wide. Each hit is also held in a small buffer. A cursor walks the bins in time order. It stops on a bin only once every hit that could affect that bin's decision has arrived. A bin that stands out from its neighbours becomes an event.

For each event, the buffer is scanned. Each hit whose timestamp lies within its detector type's half-width of the event bin's centre produces one tag. A tag carries the event id, the hit index and a downstream destination. The destination is chosen when the event is formed and never changes. A hit that lies inside several events' windows is tagged once for each of them. Hits leave the buffer once no later event can reach them. The tag rate is visible on the output stream, so a consumer can use it to pace downstream data flow.

The timebase is internal. It counts one tick per clock from zero when reset is released. Hits must arrive in nondecreasing timestamp order, at most 16 ticks after their own timestamp.

Top module: `evtag_top`

## Requirements
- R1: A hit with timestamp ts counts toward bin floor(ts/8); ts 87 and ts 88 fall in adjacent bins.
- R2: Bin b is an event when its count is at least cfg_thresh, strictly greater than the count of bin b-1, and at least the count of bin b+1. Two equal neighbours therefore yield one event, on the earlier bin.
- R3: Events receive ids 0, 1, 2 … after reset, one per qualifying bin, in ascending bin order. Every tag of an event carries that event's id.
- R4: The event of bin b tags a hit exactly when |ts − (8b+4)| ≤ W. W is the half-width of the hit's detector type d, read from cfg_win[4d+3:4d]. A half-width of 0 accepts only the centre tick.
- R5: A hit that lies inside the windows of k events is tagged k times, once per event.
- R6: The destination starts at 0 for the first event after reset. It advances by one per event and returns to 0 after cfg_ndest−1. A cfg_ndest of 0 behaves as 1. All tags of one event share one destination.
- R7: Tags leave at most one per cycle. They are grouped by event in ascending id, and within an event they follow hit arrival order.
- R8: tag_valid is low while reset is asserted, and ids and destinations restart after reset.
- R9: With hits arriving per the timing contract (in order, within 16 ticks, never more than 32 held), the tags of the bin-b event appear no earlier than cycle 8b+48 after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per cycle |
| rst | input | 1 | Synchronous reset, active high |
| hit_valid | input | 1 | A hit is presented this cycle |
| hit_ts | input | 16 | Hit timestamp in ticks |
| hit_det | input | 2 | Detector type of the hit |
| hit_idx | input | 8 | Index identifying the hit |
| cfg_thresh | input | 8 | Minimum bin count for an event |
| cfg_win | input | 16 | Four 4-bit half-widths, type d at bits [4d+3:4d] |
| cfg_ndest | input | 4 | Number of destinations (0 acts as 1) |
| tag_valid | output | 1 | A tag is presented this cycle |
| tag_event | output | 8 | Event id of the tag |
| tag_idx | output | 8 | Index of the tagged hit |
| tag_dest | output | 4 | Destination of the event |

## Verification
Two activities can fall in the same cycle. One is the insertion of a new hit, which increments the histogram and writes the buffer. The other is the scan or retirement of older hits for an earlier bin. Dense clusters are driven back to back, so new hits keep arriving while the previous peak is still being scanned and old entries are still being popped. The captured tag stream is compared entry by entry with a list that the bench derives arithmetically from the hit list and the configuration. This covers event ids, indices, destinations, duplicates for shared hits, and the earliest legal cycle of each event.

// File: rtl/evtag_pkg.sv
package evtag_pkg;
    parameter int TS_W   = 16;
    parameter int BIN_SH = 3;
    parameter int HBIN_W = 6;
    parameter int CNT_W  = 8;
    parameter int WIN_W  = 4;
    parameter int DET_W  = 2;
    parameter int IDX_W  = 8;
    parameter int EID_W  = 8;
    parameter int DEST_W = 4;

    localparam int NBINS     = 1 << HBIN_W;
    localparam int NDET      = 1 << DET_W;
    localparam int BIN_TICKS = 1 << BIN_SH;
    localparam int WIN_MAX   = (1 << WIN_W) - 1;
    localparam int CUR_W     = TS_W - BIN_SH;

    typedef struct packed {
        logic [TS_W-1:0]  ts;
        logic [DET_W-1:0] det;
        logic [IDX_W-1:0] idx;
    } hit_t;

    typedef enum logic [1:0] {
        PH_EVAL   = 2'd0,
        PH_SCAN   = 2'd1,
        PH_RETIRE = 2'd2
    } phase_e;

    // distance between two ticks on the wrapping timebase, compared to a half-width
    function automatic logic in_window(input logic [TS_W-1:0] ts,
                                       input logic [TS_W-1:0] centre,
                                       input logic [WIN_W-1:0] half);
        logic [TS_W-1:0] diff;
        logic [TS_W-1:0] mag;
        diff = ts - centre;
        mag  = diff[TS_W-1] ? (centre - ts) : diff;
        return mag <= TS_W'(half);
    endfunction
endpackage

// File: rtl/evtag_hist.sv
module evtag_hist
    import evtag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              inc_en,
    input  logic [HBIN_W-1:0] inc_bin,
    input  logic              clr_en,
    input  logic [HBIN_W-1:0] clr_bin,
    input  logic [HBIN_W-1:0] rd_bin,
    output logic [CNT_W-1:0]  cnt_left,
    output logic [CNT_W-1:0]  cnt_mid,
    output logic [CNT_W-1:0]  cnt_right
);
    typedef struct packed {
        logic [NBINS-1:0][CNT_W-1:0] cnt;
    } hist_t;

    hist_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (clr_en) begin
            h_d.cnt[clr_bin] = '0;
        end
        if (inc_en && (h_q.cnt[inc_bin] != {CNT_W{1'b1}})) begin
            h_d.cnt[inc_bin] = h_q.cnt[inc_bin] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign cnt_left  = h_q.cnt[rd_bin - 1'b1];
    assign cnt_mid   = h_q.cnt[rd_bin];
    assign cnt_right = h_q.cnt[rd_bin + 1'b1];

    // a bin being retired must never receive a hit in the same cycle
    p_no_clash_r9: assert property (@(posedge clk) disable iff (rst)
        !(inc_en && clr_en && (inc_bin == clr_bin)))
        else $error("histogram clear and increment hit the same bin");

    // R1: a bin that is neither cleared nor incremented keeps its count
    p_bin_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!clr_en && !inc_en) |=> $stable(h_q))
        else $error("histogram changed without a hit or a clear");
endmodule

// File: rtl/evtag_hitbuf.sv
module evtag_hitbuf
    import evtag_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  hit_t                   wr_hit,
    input  logic                   pop,
    input  logic [$clog2(DEPTH):0] rd_ptr,
    output hit_t                   rd_hit,
    output logic [TS_W-1:0]        head_ts,
    output logic [$clog2(DEPTH):0] head,
    output logic [$clog2(DEPTH):0] tail,
    output logic                   empty
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        hit_t [DEPTH-1:0] mem;
        logic [AW:0]      head;
        logic [AW:0]      tail;
    } buf_t;

    buf_t b_d, b_q;
    logic full;
    hit_t last_hit;

    always_comb begin
        b_d = b_q;
        if (wr_en) begin
            b_d.mem[b_q.tail[AW-1:0]] = wr_hit;
            b_d.tail = b_q.tail + 1'b1;
        end
        if (pop) begin
            b_d.head = b_q.head + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign rd_hit   = b_q.mem[rd_ptr[AW-1:0]];
    assign head_ts  = b_q.mem[b_q.head[AW-1:0]].ts;
    assign head     = b_q.head;
    assign tail     = b_q.tail;
    assign empty    = (b_q.head == b_q.tail);
    assign full     = (b_q.head[AW] != b_q.tail[AW]) && (b_q.head[AW-1:0] == b_q.tail[AW-1:0]);
    assign last_hit = b_q.mem[b_q.tail[AW-1:0] - 1'b1];

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !full)
        else $error("hit buffer overflow");

    p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty)
        else $error("retire from an empty hit buffer");

    p_ts_order_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !empty) |-> !(TS_W'(wr_hit.ts - last_hit.ts) >> (TS_W-1)))
        else $error("hit timestamps out of order");
endmodule

// File: rtl/evtag_top.sv
module evtag_top
    import evtag_pkg::*;
#(
    parameter int BUF_DEPTH = 32,
    parameter int HIT_LAG   = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    hit_valid,
    input  logic [TS_W-1:0]         hit_ts,
    input  logic [DET_W-1:0]        hit_det,
    input  logic [IDX_W-1:0]        hit_idx,
    input  logic [CNT_W-1:0]        cfg_thresh,
    input  logic [NDET*WIN_W-1:0]   cfg_win,
    input  logic [DEST_W-1:0]       cfg_ndest,
    output logic                    tag_valid,
    output logic [EID_W-1:0]        tag_event,
    output logic [IDX_W-1:0]        tag_idx,
    output logic [DEST_W-1:0]       tag_dest
);
    localparam int AW       = $clog2(BUF_DEPTH);
    // ticks from a bin's start until its neighbour and all reachable hits are in
    localparam int EVAL_GAP = 2 * BIN_TICKS + WIN_MAX + HIT_LAG;

    typedef struct packed {
        phase_e              ph;
        logic [CUR_W-1:0]    cur;
        logic [TS_W-1:0]     now;
        logic [AW:0]         scan;
        logic [AW:0]         stop;
        logic [EID_W-1:0]    eid;
        logic [DEST_W-1:0]   dest;
        logic                tv;
        logic [EID_W-1:0]    tev;
        logic [IDX_W-1:0]    tidx;
        logic [DEST_W-1:0]   tdest;
    } st_t;

    st_t s_d, s_q;

    logic [CNT_W-1:0]  c_left, c_mid, c_right;
    hit_t              wr_hit, rd_hit;
    logic [TS_W-1:0]   head_ts;
    logic [AW:0]       head, tail;
    logic              empty, pop, clr_en;
    logic [TS_W-1:0]   centre, next_centre, elapsed, age_gap;
    logic [WIN_W-1:0]  hit_half;
    logic [DEST_W-1:0] ndest_eff;
    logic              eval_ready, is_peak, retire_ok;

    assign wr_hit = '{ts: hit_ts, det: hit_det, idx: hit_idx};

    evtag_hist hist_i (
        .clk       (clk),
        .rst       (rst),
        .inc_en    (hit_valid),
        .inc_bin   (hit_ts[BIN_SH +: HBIN_W]),
        .clr_en    (clr_en),
        .clr_bin   (s_q.cur[HBIN_W-1:0] - 1'b1),
        .rd_bin    (s_q.cur[HBIN_W-1:0]),
        .cnt_left  (c_left),
        .cnt_mid   (c_mid),
        .cnt_right (c_right)
    );

    evtag_hitbuf #(.DEPTH(BUF_DEPTH)) buf_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (hit_valid),
        .wr_hit  (wr_hit),
        .pop     (pop),
        .rd_ptr  (s_q.scan),
        .rd_hit  (rd_hit),
        .head_ts (head_ts),
        .head    (head),
        .tail    (tail),
        .empty   (empty)
    );

    assign centre      = {s_q.cur, BIN_SH'(BIN_TICKS / 2)};
    assign next_centre = centre + TS_W'(BIN_TICKS);
    assign elapsed     = s_q.now - {s_q.cur, {BIN_SH{1'b0}}};
    assign eval_ready  = elapsed >= TS_W'(EVAL_GAP);
    assign is_peak     = (c_mid >= cfg_thresh) && (c_mid > c_left) && (c_mid >= c_right);
    assign hit_half    = cfg_win[rd_hit.det * WIN_W +: WIN_W];
    assign ndest_eff   = (cfg_ndest == '0) ? DEST_W'(1) : cfg_ndest;
    assign age_gap     = next_centre - head_ts;
    // no later event centre can come within reach of the oldest hit
    assign retire_ok   = !empty && !age_gap[TS_W-1] && (age_gap > TS_W'(WIN_MAX));

    always_comb begin
        s_d     = s_q;
        s_d.now = s_q.now + 1'b1;
        s_d.tv  = 1'b0;
        pop     = 1'b0;
        clr_en  = 1'b0;
        case (s_q.ph)
            PH_EVAL: begin
                if (eval_ready) begin
                    if (is_peak) begin
                        s_d.ph   = PH_SCAN;
                        s_d.scan = head;
                        s_d.stop = tail;
                    end else begin
                        s_d.ph = PH_RETIRE;
                    end
                end
            end
            PH_SCAN: begin
                if (s_q.scan == s_q.stop) begin
                    s_d.eid  = s_q.eid + 1'b1;
                    s_d.dest = (({1'b0, s_q.dest} + 1'b1) >= {1'b0, ndest_eff}) ? '0 : s_q.dest + 1'b1;
                    s_d.ph   = PH_RETIRE;
                end else begin
                    if (in_window(rd_hit.ts, centre, hit_half)) begin
                        s_d.tv    = 1'b1;
                        s_d.tev   = s_q.eid;
                        s_d.tidx  = rd_hit.idx;
                        s_d.tdest = s_q.dest;
                    end
                    s_d.scan = s_q.scan + 1'b1;
                end
            end
            PH_RETIRE: begin
                if (retire_ok) begin
                    pop = 1'b1;
                end else begin
                    clr_en  = 1'b1;
                    s_d.cur = s_q.cur + 1'b1;
                    s_d.ph  = PH_EVAL;
                end
            end
            default: s_d.ph = PH_EVAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tag_valid = s_q.tv;
    assign tag_event = s_q.tev;
    assign tag_idx   = s_q.tidx;
    assign tag_dest  = s_q.tdest;

    p_cursor_gate_r9: assert property (@(posedge clk) disable iff (rst)
        (s_q.cur != $past(s_q.cur)) |->
        (($past(s_q.now) - {$past(s_q.cur), {BIN_SH{1'b0}}}) >= TS_W'(EVAL_GAP)))
        else $error("cursor moved before its bin was complete");

    p_dest_range_r6: assert property (@(posedge clk) disable iff (rst)
        tag_valid |-> (tag_dest < ndest_eff))
        else $error("destination outside the configured range");

    p_tag_from_scan_r4: assert property (@(posedge clk) disable iff (rst)
        tag_valid |-> $past(s_q.ph == PH_SCAN))
        else $error("tag issued outside a scan");

    p_event_steady_r3: assert property (@(posedge clk) disable iff (rst)
        (tag_valid && $past(tag_valid)) |-> (tag_event == $past(tag_event)))
        else $error("event id changed between back-to-back tags");
endmodule

// File: tb/evtag_top_tb_top.sv
module evtag_top_tb_top;
    import evtag_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int HIT_LAG    = 16;
    localparam int EVAL_GAP   = 2 * BIN_TICKS + WIN_MAX + HIT_LAG;
    localparam int MAXH = 128;
    localparam int MAXB = 128;
    localparam int MAXT = 512;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hit_valid = 1'b0;
    logic [TS_W-1:0] hit_ts = '0;
    logic [DET_W-1:0] hit_det = '0;
    logic [IDX_W-1:0] hit_idx = '0;
    logic [CNT_W-1:0] cfg_thresh = '0;
    logic [NDET*WIN_W-1:0] cfg_win = '0;
    logic [DEST_W-1:0] cfg_ndest = '0;
    logic tag_valid;
    logic [EID_W-1:0] tag_event;
    logic [IDX_W-1:0] tag_idx;
    logic [DEST_W-1:0] tag_dest;

    always #(CLK_PERIOD / 2) clk = ~clk;

    evtag_top #(.BUF_DEPTH(32), .HIT_LAG(HIT_LAG)) dut_i (
        .clk(clk), .rst(rst), .hit_valid(hit_valid), .hit_ts(hit_ts),
        .hit_det(hit_det), .hit_idx(hit_idx), .cfg_thresh(cfg_thresh),
        .cfg_win(cfg_win), .cfg_ndest(cfg_ndest), .tag_valid(tag_valid),
        .tag_event(tag_event), .tag_idx(tag_idx), .tag_dest(tag_dest)
    );

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;
    int wd = 0;

    int h_ts[MAXH];
    int h_det[MAXH];
    int nh;
    int e_ev[MAXT], e_idx[MAXT], e_dest[MAXT];
    int nexp;
    int ev_bin[MAXT];
    int nev;
    int c_ev[MAXT], c_idx[MAXT], c_dest[MAXT], c_cyc[MAXT];
    int ncap;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else cyc <= cyc + 1;
    end

    always @(negedge clk) begin
        if (rst) begin
            ncap = 0;
        end else if (tag_valid && ncap < MAXT) begin
            c_ev[ncap]   = int'(tag_event);
            c_idx[ncap]  = int'(tag_idx);
            c_dest[ncap] = int'(tag_dest);
            c_cyc[ncap]  = cyc;
            ncap++;
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    endtask

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", wd);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic add_hit(input int ts, input int det);
        h_ts[nh]  = ts;
        h_det[nh] = det;
        nh++;
    endtask

    // arithmetic model of binning, peak rule, windows, ids and destinations
    task automatic build_expect(input int thr, input logic [15:0] win, input int nd);
        int cnt[MAXB];
        int dest;
        int nd_eff;
        for (int b = 0; b < MAXB; b++) cnt[b] = 0;
        for (int i = 0; i < nh; i++) cnt[h_ts[i] / 8]++;           // R1
        nd_eff = (nd == 0) ? 1 : nd;
        dest = 0;
        nev = 0;
        nexp = 0;
        for (int b = 0; b < MAXB - 1; b++) begin
            int l;
            l = (b > 0) ? cnt[b-1] : 0;
            if (cnt[b] >= thr && cnt[b] > l && cnt[b] >= cnt[b+1]) begin   // R2
                for (int i = 0; i < nh; i++) begin
                    int w, d;
                    w = int'((win >> (4 * h_det[i])) & 16'hF);
                    d = h_ts[i] - (8 * b + 4);
                    if (d < 0) d = -d;
                    if (d <= w) begin                                        // R4 R5
                        e_ev[nexp]   = nev;
                        e_idx[nexp]  = i;
                        e_dest[nexp] = dest;
                        nexp++;
                    end
                end
                ev_bin[nev] = b;
                nev++;
                dest = (dest + 1 == nd_eff) ? 0 : dest + 1;                  // R6
            end
        end
    endtask

    task automatic run_scn(input string name, input int thr, input logic [15:0] win, input int nd);
        @(negedge clk);
        rst = 1'b1;
        cfg_thresh = CNT_W'(thr);
        cfg_win = win;
        cfg_ndest = DEST_W'(nd);
        repeat (3) @(negedge clk);
        check(tag_valid == 1'b0, "R8", {name, " tag_valid in reset"}, int'(tag_valid), 0);
        build_expect(thr, win, nd);
        rst = 1'b0;
        for (int i = 0; i < nh; i++) begin
            while (cyc < h_ts[i] + 2) @(negedge clk);
            hit_valid = 1'b1;
            hit_ts = TS_W'(h_ts[i]);
            hit_det = DET_W'(h_det[i]);
            hit_idx = IDX_W'(i);
            @(negedge clk);
            hit_valid = 1'b0;
        end
        while (cyc < h_ts[nh-1] + 400) @(negedge clk);
        check(ncap == nexp, "R5", {name, " tag count"}, ncap, nexp);
        for (int i = 0; i < ncap && i < nexp; i++) begin
            check(c_ev[i] == e_ev[i], "R3", {name, " event id"}, c_ev[i], e_ev[i]);
            check(c_idx[i] == e_idx[i], "R7", {name, " hit index order"}, c_idx[i], e_idx[i]);
            check(c_dest[i] == e_dest[i], "R6", {name, " destination"}, c_dest[i], e_dest[i]);
            if ((i == 0 || c_ev[i] != c_ev[i-1]) && c_ev[i] < nev)
                check(c_cyc[i] >= 8 * ev_bin[c_ev[i]] + EVAL_GAP + 1, "R9",
                      {name, " earliest tag cycle"}, c_cyc[i], 8 * ev_bin[c_ev[i]] + EVAL_GAP + 1);
        end
    endtask

    initial begin
        // S1: overlapping events, a shared hit, exact-centre window of 0 (R4 R5)
        nh = 0;
        add_hit(30, 3);
        add_hit(40, 0); add_hit(41, 1); add_hit(43, 0);
        add_hit(44, 2); add_hit(44, 2); add_hit(46, 1);
        add_hit(50, 3); add_hit(52, 1);
        add_hit(57, 0); add_hit(58, 3); add_hit(60, 2);
        add_hit(60, 1); add_hit(61, 0); add_hit(62, 3);
        run_scn("overlap", 3, {4'd15, 4'd0, 4'd10, 4'd4}, 3);
        check(nev == 2, "R2", "overlap model event count", nev, 2);

        // S2: plateau tie, bin edge 87/88 (R1), sub-threshold bin, ndest 0 (R6)
        nh = 0;
        add_hit(81, 0); add_hit(84, 1); add_hit(87, 2);
        add_hit(88, 3); add_hit(90, 0); add_hit(94, 1);
        add_hit(162, 0); add_hit(165, 1);
        add_hit(241, 2); add_hit(244, 3);
        add_hit(249, 0); add_hit(250, 1); add_hit(252, 2); add_hit(255, 3);
        add_hit(258, 0); add_hit(259, 1); add_hit(261, 2); add_hit(263, 3);
        run_scn("plateau", 3, {4'd9, 4'd6, 4'd3, 4'd12}, 0);
        check(nev == 2, "R1", "plateau model event count", nev, 2);

        // S3: sweep of cluster sizes with noise between clusters
        nh = 0;
        for (int k = 0; k < 12; k++) begin
            for (int j = 0; j < 1 + (k % 5); j++) add_hit(8 * (4 + 5 * k) + j, (k + j) % 4);
            add_hit(8 * (6 + 5 * k) + 3, 3);
        end
        run_scn("sweep", 2, {4'd7, 4'd3, 4'd12, 4'd1}, 4);

        // S4: isolated single hits, destinations wrap many times
        nh = 0;
        for (int k = 1; k <= 30; k++) add_hit(24 * k + (k % 8), k % 4);
        run_scn("singles", 1, {4'd9, 4'd5, 4'd2, 4'd0}, 5);
        check(nev == 30, "R3", "singles model event count", nev, 30);

        summary();
        $finish;
    end
endmodule